// File: doc/BRIEF.md
# Stage Timing-Error Collector

This block gathers the transition-detect pulses produced by the error-detecting latches of one pipeline stage and turns them into a single stage-level verdict. Each small set-only memory cell watches a few detectors and remembers any pulse seen while the stage enable is high. The cell is cleared while the enable is low. At the end of the resiliency window a sample strobe captures the remembered state. After a wait that stands in for metastability resolution, the verdict is reported on a two-wire code: one wire for "error" and one for "clean".

The model works at cycle level on a system clock. The enable reaches the cells through a compensation delay of whole cycles, so a detector pulse that lines up with the opening of the window is not taken as a violation. Detectors are grouped three to a cell and four cells to a sampler. Samplers combine into the stage code through an OR tree for the error wire and an AND tree for the clean wire. The code stays at neutral (both wires low) until the resolve wait ends and again after the strobe falls.

Top module: `ecu_collect`

## Requirements
- R1: After synchronous reset, err_hit, err_miss and err_valid are all 0.
- R2: A detect pulse on any input in a cycle where the compensated enable is high (with the default one-cycle compensation: window cycles 1 to W-2 of a W-cycle enable window whose last cycle carries the strobe rise) produces err_hit=1, err_miss=0 in the result.
- R3: Pulses applied while the enable is low, and errors caught in an earlier window, do not appear in the result of a later window. The cells clear while the compensated enable is low.
- R4: With the default compensation delay of one cycle, a pulse in the first cycle of the enable window is not flagged.
- R5: The cells are sampled once, in the cycle the strobe is first seen high. A pulse in that cycle or later does not change the result.
- R6: Detect inputs are grouped three per cell (bits 3g..3g+2 feed cell g) and four cells per sampler. A pulse on any single input bit sets err_hit.
- R7: err_miss=1 only when every sampler saw no pulse in the window.
- R8: err_hit and err_miss are never both 1. Once a result appears it holds unchanged while the strobe stays high.
- R9: With resolve setting N captured in the strobe-rise cycle S, the outputs are neutral through cycle S+2+N and carry the result from cycle S+3+N on. res_cycles is ignored in every other cycle.
- R10: Two cycles after the strobe is first seen low, both wires return to 0.
- R11: err_valid is 1 exactly when one of err_hit or err_miss is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| det_pulse | input | NUM_LATCH | Transition-detect pulses, one per latch |
| lat_en | input | 1 | Stage latch enable (transparency window) |
| smp_strobe | input | 1 | Sample strobe; its rise samples, its fall clears |
| res_cycles | input | RES_W | Resolve wait in cycles, captured at the strobe rise |
| err_hit | output | 1 | Error wire of the dual-rail code |
| err_miss | output | 1 | Clean wire of the dual-rail code |
| err_valid | output | 1 | High when the code is not neutral |

## Verification
Let S be the cycle in which the strobe is first seen high. The verdict is due in cycle S+3+N: one cycle for the capture, N+1 cycles in the resolve counter, and one for the merge register. Neutral is due two cycles after the strobe is first seen low. The bench drives inputs 1 ns after each rising edge and reads the outputs at the same point, so every read shows the state after the edge just passed. It checks the cycle just before the verdict (must be neutral), the verdict cycle, the last held cycle and the return to neutral. The expected verdict comes from the pulses the bench placed in cycles 1 to W-2 of each window.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  typedef enum logic [1:0] {
    SMP_IDLE = 2'd0,
    SMP_WAIT = 2'd1,
    SMP_HOLD = 2'd2
  } smp_state_t;
endpackage

// File: rtl/ecu_comp_dly.sv
module ecu_comp_dly #(
  parameter int DLY = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic en_o
);
  generate
    if (DLY == 0) begin : g_none
      assign en_o = en_i;
    end else if (DLY == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= en_i;
      end
      assign en_o = q;
    end else begin : g_many
      logic [DLY-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DLY-2:0], en_i};
      end
      assign en_o = sr[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/ecu_sticky_cell.sv
module ecu_sticky_cell #(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_c,
  input  logic [N_IN-1:0] det,
  output logic            cell_o
);
  // set-only while enabled, cleared whenever the enable is low
  always_ff @(posedge clk) begin
    if (rst || !en_c) cell_o <= 1'b0;
    else if (|det)    cell_o <= 1'b1;
  end
endmodule

// File: rtl/ecu_sampler.sv
module ecu_sampler
  import ecu_pkg::*;
#(
  parameter int N_CELL = 4,
  parameter int RES_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CELL-1:0] cells,
  input  logic              strb_lvl,
  input  logic              strb_rise,
  input  logic [RES_W-1:0]  res_n,
  output logic              hit_o,
  output logic              miss_o
);
  smp_state_t       st;
  logic             cap;
  logic [RES_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SMP_IDLE;
      cap    <= 1'b0;
      cnt    <= '0;
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
    end else if (!strb_lvl) begin
      st     <= SMP_IDLE;
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
    end else begin
      case (st)
        SMP_IDLE: begin
          if (strb_rise) begin
            cap <= |cells;
            cnt <= res_n;
            st  <= SMP_WAIT;
          end
        end
        SMP_WAIT: begin
          if (cnt == '0) begin
            st     <= SMP_HOLD;
            hit_o  <= cap;
            miss_o <= ~cap;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ecu_merge.sv
module ecu_merge #(
  parameter int N_SMP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SMP-1:0] hit_v,
  input  logic [N_SMP-1:0] miss_v,
  output logic             hit_o,
  output logic             miss_o,
  output logic             valid_o
);
  logic any_hit, all_miss;
  assign any_hit  = |hit_v;
  assign all_miss = &miss_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      hit_o   <= any_hit;
      miss_o  <= all_miss;
      valid_o <= any_hit | all_miss;
    end
  end
endmodule

// File: rtl/ecu_collect.sv
module ecu_collect
  import ecu_pkg::*;
#(
  parameter int NUM_LATCH    = 24,
  parameter int LAT_PER_CELL = 3,
  parameter int CELL_PER_SMP = 4,
  parameter int COMP_DLY     = 1,
  parameter int RES_W        = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LATCH-1:0] det_pulse,
  input  logic                 lat_en,
  input  logic                 smp_strobe,
  input  logic [RES_W-1:0]     res_cycles,
  output logic                 err_hit,
  output logic                 err_miss,
  output logic                 err_valid
);
  localparam int NUM_CELL = NUM_LATCH / LAT_PER_CELL;
  localparam int NUM_SMP  = NUM_CELL / CELL_PER_SMP;

  logic                en_c;
  logic                strb_q;
  logic                strb_rise;
  logic [NUM_CELL-1:0] cell_v;
  logic [NUM_SMP-1:0]  s_hit;
  logic [NUM_SMP-1:0]  s_miss;

  ecu_comp_dly #(.DLY(COMP_DLY)) u_comp (
    .clk(clk), .rst(rst), .en_i(lat_en), .en_o(en_c)
  );

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b0;
    else     strb_q <= smp_strobe;
  end
  assign strb_rise = smp_strobe & ~strb_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CELL; g++) begin : g_cell
      ecu_sticky_cell #(.N_IN(LAT_PER_CELL)) u_cell (
        .clk(clk), .rst(rst), .en_c(en_c),
        .det(det_pulse[g*LAT_PER_CELL +: LAT_PER_CELL]),
        .cell_o(cell_v[g])
      );
    end
    for (g = 0; g < NUM_SMP; g++) begin : g_smp
      ecu_sampler #(.N_CELL(CELL_PER_SMP), .RES_W(RES_W)) u_smp (
        .clk(clk), .rst(rst),
        .cells(cell_v[g*CELL_PER_SMP +: CELL_PER_SMP]),
        .strb_lvl(smp_strobe), .strb_rise(strb_rise),
        .res_n(res_cycles),
        .hit_o(s_hit[g]), .miss_o(s_miss[g])
      );
    end
  endgenerate

  ecu_merge #(.N_SMP(NUM_SMP)) u_merge (
    .clk(clk), .rst(rst), .hit_v(s_hit), .miss_v(s_miss),
    .hit_o(err_hit), .miss_o(err_miss), .valid_o(err_valid)
  );
endmodule

// File: rtl/ecu_collect_chk.sv
module ecu_collect_chk (
  input logic clk,
  input logic rst,
  input logic smp_strobe,
  input logic err_hit,
  input logic err_miss,
  input logic err_valid
);
  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(err_hit && err_miss)); // R8
  AST_VALID_RAIL: assert property (@(posedge clk) disable iff (rst)
    err_valid == (err_hit ^ err_miss)); // R11
  AST_RISE_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_strobe) |=> !err_valid); // R9
  AST_FALL_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    $past(!smp_strobe, 2) |-> !err_valid); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (err_valid && $past(smp_strobe)) |=> (err_valid && $stable(err_hit))); // R8
endmodule

bind ecu_collect ecu_collect_chk u_chk (
  .clk(clk), .rst(rst), .smp_strobe(smp_strobe),
  .err_hit(err_hit), .err_miss(err_miss), .err_valid(err_valid)
);

// File: tb/tb_ecu_collect.sv
module tb_ecu_collect;
  localparam int NL = 24;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] det_pulse = '0;
  logic          lat_en = 1'b0;
  logic          smp_strobe = 1'b0;
  logic [RW-1:0] res_cycles = '0;
  logic          err_hit, err_miss, err_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [NL-1:0] sched [0:15];
  logic [NL-1:0] one = 1;

  always #10 clk = ~clk;

  ecu_collect #(.NUM_LATCH(NL), .RES_W(RW)) dut (
    .clk(clk), .rst(rst), .det_pulse(det_pulse), .lat_en(lat_en),
    .smp_strobe(smp_strobe), .res_cycles(res_cycles),
    .err_hit(err_hit), .err_miss(err_miss), .err_valid(err_valid)
  );

  function automatic logic [2:0] out_now();
    return {err_valid, err_hit, err_miss};
  endfunction

  task automatic check(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act={v,h,m}=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // R2 R4 R5: only pulses in window cycles 1..W-2 count
  function automatic bit exp_err(input int w);
    bit e = 1'b0;
    for (int j = 1; j <= w - 2; j++) e |= |sched[j];
    return e;
  endfunction

  task automatic clear_sched();
    for (int j = 0; j < 16; j++) sched[j] = '0;
  endtask

  task automatic run_window(input int w, input int n, input string tag);
    int s, f;
    bit e;
    logic [2:0] expv;
    s = w - 1;
    f = s + n + 6;
    e = exp_err(w);
    expv = {1'b1, e, ~e};
    // gap: enable low, noisy detectors (R3)
    for (int g = 0; g < 3; g++) begin
      lat_en = 1'b0; smp_strobe = 1'b0;
      det_pulse = NL'($urandom) | NL'($urandom);
      res_cycles = RW'($urandom);
      @(posedge clk); #1;
    end
    for (int c = 0; c <= f + 2; c++) begin
      int k;
      lat_en     = (c < w);
      smp_strobe = (c >= s) && (c < f);
      det_pulse  = (c < w) ? sched[c] : NL'($urandom);
      res_cycles = (c == s) ? RW'(n) : RW'($urandom);
      @(posedge clk); #1;
      k = c + 1;
      check(!(err_hit && err_miss) && (err_valid == (err_hit ^ err_miss)),
            "R8/R11", out_now(), {err_hit ^ err_miss, err_hit, err_miss});
      if (k == s + 2 + n) check(out_now() == 3'b000, "R9 early", out_now(), 3'b000);
      if (k == s + 3 + n) check(out_now() == expv, {tag, " R9 result"}, out_now(), expv);
      if (k == f + 1)     check(out_now() == expv, "R8 hold", out_now(), expv);
      if (k == f + 2)     check(out_now() == 3'b000, "R10 neutral", out_now(), 3'b000);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    det_pulse = '1; smp_strobe = 1'b1; lat_en = 1'b1;
    @(posedge clk); #1;
    check(out_now() == 3'b000, "R1 reset", out_now(), 3'b000);
    rst = 1'b0; det_pulse = '0; smp_strobe = 1'b0; lat_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;

    clear_sched();
    run_window(6, 0, "R7 clean");
    clear_sched(); sched[1] = one;
    run_window(6, 1, "R2 first-counted");
    clear_sched(); sched[0] = '1;
    run_window(6, 2, "R4 comp");
    clear_sched(); sched[5] = '1;
    run_window(6, 0, "R5 after-sample");
    clear_sched(); sched[3] = one << (NL - 1);
    run_window(6, 15, "R9 max-resolve");
    clear_sched();
    run_window(5, 3, "R3 after-dirty");
    for (int b = 0; b < NL; b++) begin
      clear_sched(); sched[2] = one << b;
      run_window(5, b % 3, "R6 bit");
    end
    for (int r = 0; r < 60; r++) begin
      int w = 4 + int'($urandom % 10);
      clear_sched();
      for (int j = 0; j < w; j++)
        sched[j] = ($urandom % 5 == 0) ? (one << ($urandom % NL)) : '0;
      run_window(w, int'($urandom % 6), "R2/R7 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule